// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This unit sits between a 32-bit integer datapath and a word-addressed, little-endian data memory. On the store side it receives the access code (the three-bit function field of the memory instruction), the effective byte address and the source register value. It returns a word address, a four-bit lane enable mask and a write word with the source bytes copied into the lanes the access covers. Byte 0 of a memory word lies on data bits 7:0.

On the load side it receives the access code, the two low address bits and the word read from memory. It picks out the addressed byte, halfword or word, then extends it to 32 bits with copies of its sign bit or with zeros. Both sides flag accesses that are not aligned to their size and access codes they do not support. A flagged store enables no lanes, and a flagged load returns zero. Each side registers its results once, so every result appears on the clock edge after its request.

Top module: `lsu_align_unit`

## Requirements
- R1: While rst_ni is low, every output is zero.
- R2: st_valid_o and ld_valid_o are high in the cycle after a clock edge that sampled st_req_i or ld_req_i high, and low after an edge that sampled it low; every other result is due in that same cycle.
- R3: mem_addr_o equals st_addr_i with bits 1:0 forced to zero.
- R4: A legal, aligned store with code 000 (byte), 001 (halfword) or 010 (word) drives mem_be_o to 4'b0001, 4'b0011 or 4'b1111 respectively, shifted left by st_addr_i[1:0].
- R5: For a store with lanes enabled, mem_wdata_o carries the low byte of st_data_i in all four lanes (code 000), the low halfword in both halves (code 001), or st_data_i unchanged (code 010).
- R6: A halfword store with address bit 0 set, or a word store with address bits 1:0 not 00, raises st_misal_o and leaves mem_be_o at zero.
- R7: A store code other than 000, 001 or 010 raises st_illegal_o, leaves st_misal_o low and mem_be_o at zero.
- R8: Load code 000 returns the byte in lane ld_off_i with its bit 7 copied into bits 31:8; code 100 returns the same byte with bits 31:8 zero.
- R9: Load code 001 returns the halfword starting at lane ld_off_i with its bit 15 copied into bits 31:16; code 101 zero-fills bits 31:16.
- R10: Load code 010 returns ld_rdata_i unchanged.
- R11: A halfword load with ld_off_i[0] set, or a word load with ld_off_i not 00, raises ld_misal_o and returns zero.
- R12: Load codes 011, 110 and 111 raise ld_illegal_o, leave ld_misal_o low and return zero.
- R13: In a cycle with no store request registered, mem_be_o, st_misal_o and st_illegal_o are zero; with no load request registered, ld_data_o, ld_misal_o and ld_illegal_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_req_i | input | 1 | Store request this cycle |
| st_funct_i | input | 3 | Store access code |
| st_addr_i | input | 32 | Store effective byte address |
| st_data_i | input | 32 | Store source register value |
| ld_req_i | input | 1 | Load data present this cycle |
| ld_funct_i | input | 3 | Load access code |
| ld_off_i | input | 2 | Load byte offset within the word |
| ld_rdata_i | input | 32 | Word read from memory |
| mem_addr_o | output | 32 | Word-aligned store address |
| mem_be_o | output | 4 | Store lane enables |
| mem_wdata_o | output | 32 | Lane-steered store data |
| st_valid_o | output | 1 | Store results valid |
| st_misal_o | output | 1 | Store misaligned |
| st_illegal_o | output | 1 | Store code unsupported |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 32 | Extended load result |
| ld_misal_o | output | 1 | Load misaligned |
| ld_illegal_o | output | 1 | Load code unsupported |

## Verification
Every result of both sides is due exactly one rising edge after the inputs that produce it are sampled: the registers on the store and load paths are the only state. The bench changes inputs on a falling edge and compares outputs on the next falling edge, halfway between the capturing edge and the one after it. It sweeps all eight access codes across all four offsets with several data words whose lane sign bits differ. Idle cycles between requests confirm that the valid flags fall one edge later and that the lane enables and flags clear with them.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  function automatic logic [1:0] size_of(input logic [2:0] funct);
    return funct[1:0];
  endfunction

  function automatic logic st_code_bad(input logic [2:0] funct);
    return funct[2] | (funct[1:0] == 2'd3);
  endfunction

  // funct[2] means unsigned; only byte and half have unsigned forms
  function automatic logic ld_code_bad(input logic [2:0] funct);
    return (funct[1:0] == 2'd3) | (funct[2] & (funct[1:0] == SZ_WORD));
  endfunction
endpackage

// File: rtl/lsu_st_steer.sv
module lsu_st_steer
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        funct_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W/8-1:0] be_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              misal_o,
  output logic              illegal_o
);
  localparam int NB = DATA_W / 8;
  localparam int OW = $clog2(NB);

  logic [1:0]        sz;
  logic [OW-1:0]     off;
  logic [OW-1:0]     amask;
  logic              bad_c;
  logic              misal_c;
  logic [NB-1:0]     be_base;
  logic [NB-1:0]     be_c;
  logic [DATA_W-1:0] wdata_c;

  always_comb begin
    sz      = size_of(funct_i);
    off     = addr_i[OW-1:0];
    amask   = OW'((32'd1 << sz) - 32'd1);
    bad_c   = st_code_bad(funct_i);
    misal_c = !bad_c && ((off & amask) != '0);
    be_base = NB'((32'd1 << (32'd1 << sz)) - 32'd1);
    be_c    = (req_i && !bad_c && !misal_c) ? (be_base << off) : '0;
  end

  // each lane copies the source byte at its position modulo the access size
  for (genvar k = 0; k < NB; k++) begin : g_lane
    logic [OW-1:0] src;
    assign src = OW'(k) & amask;
    assign wdata_c[8*k +: 8] = data_i[8*src +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      addr_o    <= '0;
      be_o      <= '0;
      wdata_o   <= '0;
      misal_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o   <= req_i;
      addr_o    <= {addr_i[ADDR_W-1:OW], {OW{1'b0}}};
      be_o      <= be_c;
      wdata_o   <= wdata_c;
      misal_o   <= req_i & misal_c;
      illegal_o <= req_i & bad_c;
    end
  end

  p_req_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  p_fault_no_be_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (misal_o || illegal_o) |-> (be_o == '0));
  p_flags_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(misal_o && illegal_o));
  p_be_shape_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(be_o) == 0) || ($countones(be_o) == 1) ||
    ($countones(be_o) == 2) || ($countones(be_o) == NB));
  p_idle_quiet_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (be_o == '0 && !misal_o && !illegal_o));
  p_word_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (addr_o[ADDR_W-1:OW] == $past(addr_i[ADDR_W-1:OW])));
endmodule

// File: rtl/lsu_ld_extract.sv
module lsu_ld_extract
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic [2:0]                 funct_i,
  input  logic [$clog2(DATA_W/8)-1:0] off_i,
  input  logic [DATA_W-1:0]          rdata_i,
  output logic                       valid_o,
  output logic [DATA_W-1:0]          data_o,
  output logic                       misal_o,
  output logic                       illegal_o
);
  localparam int NB = DATA_W / 8;
  localparam int OW = $clog2(NB);

  logic [1:0]        sz;
  logic [OW-1:0]     amask;
  logic              bad_c;
  logic              misal_c;
  logic              fill;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] ext_c;

  always_comb begin
    sz      = size_of(funct_i);
    amask   = OW'((32'd1 << sz) - 32'd1);
    bad_c   = ld_code_bad(funct_i);
    misal_c = !bad_c && ((off_i & amask) != '0);
    sh      = rdata_i >> {off_i, 3'b000};
    fill    = 1'b0;
    ext_c   = sh;
    case (sz)
      SZ_BYTE: begin
        fill  = !funct_i[2] & sh[7];
        ext_c = {{(DATA_W-8){fill}}, sh[7:0]};
      end
      SZ_HALF: begin
        fill  = !funct_i[2] & sh[15];
        ext_c = {{(DATA_W-16){fill}}, sh[15:0]};
      end
      default: ext_c = sh;
    endcase
    if (bad_c || misal_c || !req_i) ext_c = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      data_o    <= '0;
      misal_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o   <= req_i;
      data_o    <= ext_c;
      misal_o   <= req_i & misal_c;
      illegal_o <= req_i & bad_c;
    end
  end

  p_ld_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  p_ld_fault_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (misal_o || illegal_o) |-> (data_o == '0));
  p_ld_flags_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(misal_o && illegal_o));
  p_ld_zext_byte_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(funct_i) == 3'b100) |-> (data_o[DATA_W-1:8] == '0));
  p_ld_zext_half_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(funct_i) == 3'b101) |-> (data_o[DATA_W-1:16] == '0));
  p_ld_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (data_o == '0 && !misal_o && !illegal_o));
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        st_req_i,
  input  logic [2:0]                  st_funct_i,
  input  logic [ADDR_W-1:0]           st_addr_i,
  input  logic [DATA_W-1:0]           st_data_i,
  input  logic                        ld_req_i,
  input  logic [2:0]                  ld_funct_i,
  input  logic [$clog2(DATA_W/8)-1:0] ld_off_i,
  input  logic [DATA_W-1:0]           ld_rdata_i,
  output logic [ADDR_W-1:0]           mem_addr_o,
  output logic [DATA_W/8-1:0]         mem_be_o,
  output logic [DATA_W-1:0]           mem_wdata_o,
  output logic                        st_valid_o,
  output logic                        st_misal_o,
  output logic                        st_illegal_o,
  output logic                        ld_valid_o,
  output logic [DATA_W-1:0]           ld_data_o,
  output logic                        ld_misal_o,
  output logic                        ld_illegal_o
);
  lsu_st_steer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_st (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (st_req_i),
    .funct_i   (st_funct_i),
    .addr_i    (st_addr_i),
    .data_i    (st_data_i),
    .valid_o   (st_valid_o),
    .addr_o    (mem_addr_o),
    .be_o      (mem_be_o),
    .wdata_o   (mem_wdata_o),
    .misal_o   (st_misal_o),
    .illegal_o (st_illegal_o)
  );

  lsu_ld_extract #(.DATA_W(DATA_W)) u_ld (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (ld_req_i),
    .funct_i   (ld_funct_i),
    .off_i     (ld_off_i),
    .rdata_i   (ld_rdata_i),
    .valid_o   (ld_valid_o),
    .data_o    (ld_data_o),
    .misal_o   (ld_misal_o),
    .illegal_o (ld_illegal_o)
  );
endmodule

// File: tb/sim_lsu_align_unit.sv
`timescale 1ns/1ps
module sim_lsu_align_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        st_req_i = 1'b0;
  logic [2:0]  st_funct_i = '0;
  logic [31:0] st_addr_i = '0;
  logic [31:0] st_data_i = '0;
  logic        ld_req_i = 1'b0;
  logic [2:0]  ld_funct_i = '0;
  logic [1:0]  ld_off_i = '0;
  logic [31:0] ld_rdata_i = '0;
  logic [31:0] mem_addr_o, mem_wdata_o, ld_data_o;
  logic [3:0]  mem_be_o;
  logic        st_valid_o, st_misal_o, st_illegal_o;
  logic        ld_valid_o, ld_misal_o, ld_illegal_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  lsu_align_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .st_req_i(st_req_i), .st_funct_i(st_funct_i), .st_addr_i(st_addr_i), .st_data_i(st_data_i),
    .ld_req_i(ld_req_i), .ld_funct_i(ld_funct_i), .ld_off_i(ld_off_i), .ld_rdata_i(ld_rdata_i),
    .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o),
    .st_valid_o(st_valid_o), .st_misal_o(st_misal_o), .st_illegal_o(st_illegal_o),
    .ld_valid_o(ld_valid_o), .ld_data_o(ld_data_o), .ld_misal_o(ld_misal_o),
    .ld_illegal_o(ld_illegal_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    case (i)
      0: return 32'h80FF_7F01;
      1: return 32'h7F80_01FE;
      2: return 32'hC3A5_5A3C;
      default: return 32'h1234_5678;
    endcase
  endfunction

  task automatic check_idle();
    chk("R2 st_valid idle", {31'd0, st_valid_o}, 32'd0);
    chk("R13 be idle", {28'd0, mem_be_o}, 32'd0);
    chk("R13 st flags idle", {30'd0, st_misal_o, st_illegal_o}, 32'd0);
    chk("R2 ld_valid idle", {31'd0, ld_valid_o}, 32'd0);
    chk("R13 ld data idle", ld_data_o, 32'd0);
    chk("R13 ld flags idle", {30'd0, ld_misal_o, ld_illegal_o}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero under reset
    chk("R1 be", {28'd0, mem_be_o}, 32'd0);
    chk("R1 addr", mem_addr_o, 32'd0);
    chk("R1 wdata", mem_wdata_o, 32'd0);
    chk("R1 st flags", {29'd0, st_valid_o, st_misal_o, st_illegal_o}, 32'd0);
    chk("R1 ld data", ld_data_o, 32'd0);
    chk("R1 ld flags", {29'd0, ld_valid_o, ld_misal_o, ld_illegal_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check_idle();

    for (int f = 0; f < 8; f++) begin
      for (int off = 0; off < 4; off++) begin
        for (int p = 0; p < 4; p++) begin
          logic [31:0] d, a, rd, sh, exp_wd, exp_ld;
          logic [3:0]  exp_be;
          logic        s_bad, s_mis, l_bad, l_mis;
          int          n;
          d  = pat(p) ^ 32'h0F0F_0000;
          a  = 32'h1000_0F30 ^ (32'(p) << 8) ^ 32'(off);
          rd = pat(p);
          // drive
          st_req_i = 1'b1; st_funct_i = 3'(f); st_addr_i = a; st_data_i = d;
          ld_req_i = 1'b1; ld_funct_i = 3'(f); ld_off_i = 2'(off); ld_rdata_i = rd;
          // expected store
          n      = 1 << (f % 4);
          s_bad  = (f >= 3);
          s_mis  = !s_bad && ((off % n) != 0);
          exp_be = (s_bad || s_mis) ? 4'd0 : 4'(((1 << n) - 1) << off);
          exp_wd = (f == 0) ? {4{d[7:0]}} : (f == 1) ? {2{d[15:0]}} : d;
          // expected load
          l_bad  = (f == 3) || (f == 6) || (f == 7);
          l_mis  = !l_bad && ((off % n) != 0);
          sh     = rd >> (off * 8);
          case (f)
            0: exp_ld = (sh[7:0] >= 8'd128) ? (32'(sh[7:0]) | 32'hFFFF_FF00) : 32'(sh[7:0]);
            4: exp_ld = 32'(sh[7:0]);
            1: exp_ld = (sh[15:0] >= 16'h8000) ? (32'(sh[15:0]) | 32'hFFFF_0000) : 32'(sh[15:0]);
            5: exp_ld = 32'(sh[15:0]);
            2: exp_ld = rd;
            default: exp_ld = 32'd0;
          endcase
          if (l_bad || l_mis) exp_ld = 32'd0;
          @(negedge clk);
          chk("R2 st_valid", {31'd0, st_valid_o}, 32'd1);
          chk("R3 word addr", mem_addr_o, a & 32'hFFFF_FFFC);
          chk(s_mis ? "R6 be" : (s_bad ? "R7 be" : "R4 be"), {28'd0, mem_be_o}, {28'd0, exp_be});
          if (exp_be != 4'd0) chk("R5 wdata", mem_wdata_o, exp_wd);
          chk("R6 st_misal", {31'd0, st_misal_o}, {31'd0, s_mis});
          chk("R7 st_illegal", {31'd0, st_illegal_o}, {31'd0, s_bad});
          chk("R2 ld_valid", {31'd0, ld_valid_o}, 32'd1);
          chk((f == 0 || f == 4) ? "R8 ld byte" : (f == 1 || f == 5) ? "R9 ld half" :
              (f == 2) ? "R10 ld word" : "R12 ld data", ld_data_o, exp_ld);
          chk("R11 ld_misal", {31'd0, ld_misal_o}, {31'd0, l_mis});
          chk("R12 ld_illegal", {31'd0, ld_illegal_o}, {31'd0, l_bad});
          // idle gap every fourth request
          if (p == 3) begin
            st_req_i = 1'b0; ld_req_i = 1'b0;
            @(negedge clk);
            check_idle();
          end
        end
      end
    end

    // reset in the middle of activity clears outputs again (R1)
    st_req_i = 1'b1; st_funct_i = 3'b010; st_addr_i = 32'h40; st_data_i = 32'hDEAD_BEEF;
    ld_req_i = 1'b1; ld_funct_i = 3'b010; ld_off_i = 2'd0; ld_rdata_i = 32'hCAFE_F00D;
    @(negedge clk);
    chk("R4 word be", {28'd0, mem_be_o}, 32'hF);
    rst_ni = 1'b0;
    #1;
    chk("R1 be async", {28'd0, mem_be_o}, 32'd0);
    chk("R1 ld async", ld_data_o, 32'd0);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule